// File: doc/BRIEF.md
# DRAM Bank Open-Row Command Sequencer

This block sits between a stream of physical read requests and one channel of DRAM devices. The channel holds 2 GB over 8 banks. Each bank has 16K rows of 2K columns, and the data bus is 8 bytes wide. Each accepted address is split into bank, row and column fields. A parameter picks one of two address layouts. In the row layout a whole row stays in one bank. In the block layout consecutive 64-byte blocks land in consecutive banks.

The sequencer remembers which row, if any, each bank holds open in its row buffer. It sorts every request into one of three cases:
- A hit needs one column read.
- An empty bank needs an activate, then a read.
- A conflict needs a precharge, an activate and then a read.

Fixed gaps, counted in controller cycles, separate activate from read and precharge from the next activate or refresh. A periodic refresh timer closes every open bank and issues a refresh command between requests. Requests are taken one at a time, in order, with a valid/ready handshake. The class of each request is reported in the same cycle as its read command.

Top module: `dram_rowbuf_ctrl`

## Requirements
- R1: `req_ready` is high only when no request is in service and no refresh is pending. Requests are served one at a time, in acceptance order, and each yields exactly one READ.
- R2: With `INTERLEAVE`=0, address bits [30:17] are the row, [16:14] the bank and [13:3] the column. Bits [2:0] (byte within the bus word) have no effect on any command field.
- R3: With `INTERLEAVE`=1, bits [30:17] are the row, [8:6] the bank, and the column is {bits [16:9], bits [5:3]}. As a result, consecutive 64-byte blocks map to consecutive banks.
- R4: A request whose bank already has the same row open issues only a READ. It reports `rsp_kind`=0 (hit).
- R5: A request to a bank with no open row issues ACTIVATE then READ. It reports `rsp_kind`=1 (empty).
- R6: A request to a bank holding a different row issues PRECHARGE, ACTIVATE, READ to that bank. It reports `rsp_kind`=2 (conflict).
- R7: A READ comes at least `T_RCD` cycles after the latest ACTIVATE.
- R8: An ACTIVATE or REFRESH comes at least `T_RP` cycles after the latest PRECHARGE.
- R9: A refresh falls due every `T_REFI` cycles. It is issued once the current request completes, after every open bank has been precharged. After it, every bank counts as empty.
- R10: Open-row state is kept per bank. Accessing one bank leaves the open row of every other bank unchanged.
- R11: After reset, no bank is open, `cmd_valid` and `rsp_valid` are low, and `req_ready` is high.

Command encoding on `cmd_op`: 0 ACTIVATE, 1 READ, 2 PRECHARGE, 3 REFRESH. `rsp_valid` is high exactly in a READ cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 31 | Physical byte address |
| cmd_valid | output | 1 | A DRAM command is issued this cycle |
| cmd_op | output | 2 | Command code (0 ACT, 1 READ, 2 PRE, 3 REF) |
| cmd_bank | output | 3 | Target bank |
| cmd_row | output | 14 | Row for ACT and READ |
| cmd_col | output | 11 | Column for READ |
| rsp_valid | output | 1 | Classification of the request being read |
| rsp_kind | output | 2 | 0 hit, 1 empty, 2 conflict |

## Verification
Several kinds of address stream are used:
- A short directed stream opens a bank, rereads its row with a different byte offset, switches to another row in that bank, and touches a second bank before returning to the first. This separates hit, empty and conflict handling, and per-bank row tracking from a single shared open row.
- A pseudo-random stream over four rows and four banks mixes all three classes. Refreshes land between requests, so each access just after a refresh must read as empty.
- A second instance in block layout receives consecutive 64-byte blocks and an address with nonzero high and low column bits. This tells the two field layouts apart.

// File: rtl/dram_rowbuf_ctrl.sv
module dram_rowbuf_ctrl #(
  parameter int ROW_W      = 14,
  parameter int BANK_W     = 3,
  parameter int COL_W      = 11,
  parameter int BYTE_W     = 3,
  parameter int LOWCOL_W   = 3,
  parameter int INTERLEAVE = 0,
  parameter int T_RCD      = 4,
  parameter int T_RP       = 4,
  parameter int T_REFI     = 1560
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic [ROW_W+BANK_W+COL_W+BYTE_W-1:0]   req_addr,
  output logic                                   cmd_valid,
  output logic [1:0]                             cmd_op,
  output logic [BANK_W-1:0]                      cmd_bank,
  output logic [ROW_W-1:0]                       cmd_row,
  output logic [COL_W-1:0]                       cmd_col,
  output logic                                   rsp_valid,
  output logic [1:0]                             rsp_kind
);
  localparam int ADDR_W  = ROW_W + BANK_W + COL_W + BYTE_W;
  localparam int NBANK   = 1 << BANK_W;
  localparam int GAP_MAX = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);
  localparam int REF_W   = $clog2(T_REFI + 1);
  localparam logic [1:0] OP_ACT = 2'd0, OP_RD = 2'd1, OP_PRE = 2'd2, OP_REF = 2'd3;
  localparam logic [1:0] K_HIT = 2'd0, K_EMPTY = 2'd1, K_CONF = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_ACT, S_RD, S_RPRE} state_t;

  state_t                state;
  logic [BANK_W-1:0]     a_bank, r_bank, victim;
  logic [ROW_W-1:0]      a_row, r_row;
  logic [COL_W-1:0]      a_col, r_col;
  logic [1:0]            r_kind, a_kind;
  logic [GAP_W-1:0]      gap;
  logic [NBANK-1:0]      open_vld;
  logic [ROW_W-1:0]      open_row [NBANK];
  logic [REF_W-1:0]      ref_cnt;
  logic                  ref_pend;
  logic                  is_act, is_pre, is_rd, is_ref, accept;

  assign a_row = req_addr[ADDR_W-1 -: ROW_W];

  generate
    if (INTERLEAVE == 0) begin : g_row_map
      assign a_col  = req_addr[BYTE_W +: COL_W];
      assign a_bank = req_addr[BYTE_W+COL_W +: BANK_W];
    end else begin : g_blk_map
      assign a_col  = {req_addr[BYTE_W+LOWCOL_W+BANK_W +: COL_W-LOWCOL_W],
                       req_addr[BYTE_W +: LOWCOL_W]};
      assign a_bank = req_addr[BYTE_W+LOWCOL_W +: BANK_W];
    end
  endgenerate

  assign a_kind    = !open_vld[a_bank] ? K_EMPTY :
                     (open_row[a_bank] == a_row) ? K_HIT : K_CONF;
  assign req_ready = (state == S_IDLE) && !ref_pend;
  assign accept    = req_ready && req_valid;

  always_comb begin
    victim = '0;
    for (int i = NBANK - 1; i >= 0; i--)
      if (open_vld[i]) victim = BANK_W'(i);
  end

  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = OP_RD;
    cmd_bank  = r_bank;
    cmd_row   = r_row;
    cmd_col   = r_col;
    case (state)
      S_PRE: begin cmd_valid = 1'b1; cmd_op = OP_PRE; end
      S_ACT: if (gap == '0) begin cmd_valid = 1'b1; cmd_op = OP_ACT; end
      S_RD:  if (gap == '0) begin cmd_valid = 1'b1; cmd_op = OP_RD; end
      S_RPRE: begin
        cmd_bank = victim;
        cmd_row  = '0;
        cmd_col  = '0;
        if (|open_vld) begin
          cmd_valid = 1'b1; cmd_op = OP_PRE;
        end else if (gap == '0) begin
          cmd_valid = 1'b1; cmd_op = OP_REF;
        end
      end
      default: ;
    endcase
  end

  assign is_act    = cmd_valid && cmd_op == OP_ACT;
  assign is_pre    = cmd_valid && cmd_op == OP_PRE;
  assign is_rd     = cmd_valid && cmd_op == OP_RD;
  assign is_ref    = cmd_valid && cmd_op == OP_REF;
  assign rsp_valid = is_rd;
  assign rsp_kind  = r_kind;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      gap      <= '0;
      open_vld <= '0;
      ref_cnt  <= '0;
      ref_pend <= 1'b0;
      r_bank   <= '0;
      r_row    <= '0;
      r_col    <= '0;
      r_kind   <= K_HIT;
    end else begin
      ref_cnt <= (ref_cnt == REF_W'(T_REFI - 1)) ? '0 : ref_cnt + 1'b1;
      if (ref_cnt == REF_W'(T_REFI - 1)) ref_pend <= 1'b1;
      else if (is_ref)                    ref_pend <= 1'b0;

      if (is_act)            gap <= GAP_W'(T_RCD - 1);
      else if (is_pre)       gap <= GAP_W'(T_RP - 1);
      else if (gap != '0)    gap <= gap - 1'b1;

      if (is_act) open_vld[cmd_bank] <= 1'b1;
      if (is_pre) open_vld[cmd_bank] <= 1'b0;

      case (state)
        S_IDLE:
          if (ref_pend) state <= S_RPRE;
          else if (accept) begin
            r_bank <= a_bank;
            r_row  <= a_row;
            r_col  <= a_col;
            r_kind <= a_kind;
            state  <= (a_kind == K_HIT) ? S_RD : (a_kind == K_EMPTY) ? S_ACT : S_PRE;
          end
        S_PRE:  state <= S_ACT;
        S_ACT:  if (gap == '0) state <= S_RD;
        S_RD:   if (gap == '0) state <= S_IDLE;
        S_RPRE: if (is_ref) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (is_act) open_row[cmd_bank] <= cmd_row;

  logic [GAP_W-1:0] since_act, since_pre;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= GAP_W'(GAP_MAX);
      since_pre <= GAP_W'(GAP_MAX);
    end else begin
      since_act <= is_act ? GAP_W'(1) : (since_act < GAP_W'(GAP_MAX)) ? since_act + 1'b1 : since_act;
      since_pre <= is_pre ? GAP_W'(1) : (since_pre < GAP_W'(GAP_MAX)) ? since_pre + 1'b1 : since_pre;
    end
  end

  p_ready_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid);
  p_act_to_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |-> since_act >= GAP_W'(T_RCD));
  p_pre_to_act_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act || is_ref) |-> since_pre >= GAP_W'(T_RP));
  p_ref_all_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> open_vld == '0);
  p_rd_open_row_r10: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |-> open_vld[cmd_bank] && open_row[cmd_bank] == cmd_row);
  p_act_closed_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> !open_vld[cmd_bank]);
endmodule

// File: tb/dram_rowbuf_ctrl_tb.sv
module dram_rowbuf_ctrl_tb;
  localparam int T_RCD  = 3;
  localparam int T_RP   = 2;
  localparam int T_REFI = 250;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [30:0] req_addr = '0;
  logic        cmd_valid, rsp_valid;
  logic [1:0]  cmd_op, rsp_kind;
  logic [2:0]  cmd_bank;
  logic [13:0] cmd_row;
  logic [10:0] cmd_col;

  logic        b_valid = 1'b0, b_ready;
  logic [30:0] b_addr = '0;
  logic        b_cmd_valid, b_rsp_valid;
  logic [1:0]  b_cmd_op, b_rsp_kind;
  logic [2:0]  b_cmd_bank;
  logic [13:0] b_cmd_row;
  logic [10:0] b_cmd_col;

  dram_rowbuf_ctrl #(.INTERLEAVE(0), .T_RCD(T_RCD), .T_RP(T_RP), .T_REFI(T_REFI)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind));

  dram_rowbuf_ctrl #(.INTERLEAVE(1), .T_RCD(T_RCD), .T_RP(T_RP), .T_REFI(100000)) u_dut_blk (
    .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_ready(b_ready), .req_addr(b_addr),
    .cmd_valid(b_cmd_valid), .cmd_op(b_cmd_op), .cmd_bank(b_cmd_bank), .cmd_row(b_cmd_row),
    .cmd_col(b_cmd_col), .rsp_valid(b_rsp_valid), .rsp_kind(b_rsp_kind));

  int n_chk = 0, n_err = 0;
  int cyc = 0, last_act = -1000, last_pre = -1000, last_ref = -1, n_ref = 0;
  int seen_kind [3] = '{0, 0, 0};
  logic        ref_flag = 1'b0;
  logic [7:0]  mon_open = '0;
  logic [7:0]  mv = '0;
  logic [13:0] mr [8];
  logic [29:0] exp_q [$];
  logic [27:0] blk_exp [$];
  logic [27:0] blk_got [$];

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [30:0] mk(input int row, input int bank, input int col, input int byt);
    return {14'(row), 3'(bank), 11'(col), 3'(byt)};
  endfunction

  task automatic send(input logic [30:0] a);
    logic [2:0]  b;
    logic [13:0] r;
    logic [1:0]  k;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    while (!req_ready) @(negedge clk);
    if (ref_flag) begin mv = '0; ref_flag = 1'b0; end
    b = a[16:14];
    r = a[30:17];
    k = !mv[b] ? 2'd1 : (mr[b] == r) ? 2'd0 : 2'd2;
    mv[b] = 1'b1;
    mr[b] = r;
    exp_q.push_back({k, b, r, a[13:3]});
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R1 ready low while busy", req_ready, 0);
  endtask

  task automatic blk_send(input logic [30:0] a);
    @(negedge clk);
    b_valid = 1'b1;
    b_addr  = a;
    while (!b_ready) @(negedge clk);
    blk_exp.push_back({a[8:6], a[30:17], a[16:9], a[5:3]});
    @(negedge clk);
    b_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (cmd_valid) begin
        case (cmd_op)
          2'd0: begin
            check(cyc - last_pre >= T_RP, "R8 PRE->ACT gap", cyc - last_pre, T_RP);
            last_act = cyc;
            mon_open[cmd_bank] = 1'b1;
          end
          2'd1: begin
            logic [29:0] e;
            check(cyc - last_act >= T_RCD, "R7 ACT->READ gap", cyc - last_act, T_RCD);
            check(mon_open[cmd_bank], "R10 READ to open bank", mon_open[cmd_bank], 1);
            check(rsp_valid, "R1 status with READ", rsp_valid, 1);
            if (exp_q.size() == 0) begin
              check(1'b0, "R1 READ without request", 1, 0);
            end else begin
              e = exp_q.pop_front();
              check({cmd_bank, cmd_row, cmd_col} == e[27:0], "R2 field mapping",
                    {cmd_bank, cmd_row, cmd_col}, e[27:0]);
              check(rsp_kind == e[29:28],
                    e[29:28] == 0 ? "R4 hit class" : e[29:28] == 1 ? "R5 empty class" : "R6 conflict class",
                    rsp_kind, e[29:28]);
              if (rsp_kind < 3) seen_kind[rsp_kind]++;
            end
          end
          2'd2: begin
            last_pre = cyc;
            mon_open[cmd_bank] = 1'b0;
          end
          default: begin
            check(mon_open == 0, "R9 banks closed at refresh", mon_open, 0);
            check(cyc - last_pre >= T_RP, "R8 PRE->REF gap", cyc - last_pre, T_RP);
            if (last_ref >= 0)
              check(cyc - last_ref > T_REFI - 30 && cyc - last_ref < T_REFI + 30,
                    "R9 refresh interval", cyc - last_ref, T_REFI);
            last_ref = cyc;
            n_ref++;
            ref_flag = 1'b1;
          end
        endcase
      end else begin
        if (rsp_valid) check(1'b0, "R1 status without READ", 1, 0);
      end
      if (b_cmd_valid && b_cmd_op == 2'd1)
        blk_got.push_back({b_cmd_bank, b_cmd_row, b_cmd_col});
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h1234_5678;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    check(req_ready == 1'b1, "R11 ready after reset", req_ready, 1);
    check(cmd_valid == 1'b0, "R11 no command after reset", cmd_valid, 0);
    check(rsp_valid == 1'b0, "R11 no status after reset", rsp_valid, 0);

    send(mk(5, 2, 10, 0));    // R5 empty
    send(mk(5, 2, 20, 7));    // R4 hit, R2 byte bits ignored
    send(mk(9, 2, 0, 0));     // R6 conflict
    send(mk(1, 4, 3, 0));     // R5 other bank
    send(mk(9, 2, 100, 3));   // R10 bank 2 kept row 9: hit
    send(mk(1, 4, 2047, 0));  // R10 bank 4 kept row 1: hit

    for (int i = 0; i < 60; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      send(mk(int'(seed[17:16]), int'(seed[20:19]), int'(seed[30:21]), int'(seed[2:0])));
    end

    // R9: after a refresh the next access to a previously open bank is empty
    begin
      int r0 = n_ref;
      while (n_ref == r0) @(negedge clk);
    end
    send(mk(9, 2, 5, 0));

    for (int i = 0; i < 60; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      send(mk(int'(seed[17:16]), int'(seed[20:19]), int'(seed[30:21]), 0));
    end

    while (cyc < 1400) @(negedge clk);
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, "R1 every request read", exp_q.size(), 0);
    check(seen_kind[0] > 0, "R4 hits observed", seen_kind[0], 1);
    check(seen_kind[1] > 0, "R5 empties observed", seen_kind[1], 1);
    check(seen_kind[2] > 0, "R6 conflicts observed", seen_kind[2], 1);
    check(n_ref >= cyc / T_REFI - 1, "R9 refresh count", n_ref, cyc / T_REFI);

    // R3: block interleaving layout
    blk_send(31'd0);
    blk_send(31'd64);
    blk_send(31'd128);
    blk_send(31'd520);
    blk_send((31'd3 << 17) | (31'd5 << 6) | 31'd4);
    repeat (20) @(negedge clk);
    check(blk_got.size() == 5, "R3 block reads count", blk_got.size(), 5);
    for (int i = 0; i < 5; i++) begin
      logic [27:0] g, e;
      e = blk_exp.pop_front();
      g = (blk_got.size() > 0) ? blk_got.pop_front() : 28'h0;
      check(g == e, "R3 block field mapping", g, e);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule